// File: doc/BRIEF.md
# Optimal Additive Increment Search

This block finds the best increment for an adder-based pattern generator. The generator starts from a seed and adds a fixed increment on every clock, wrapping modulo 2^NB. It must pass through every vector in a small set, and the block picks the increment that makes the longest wait for any vector as short as possible. Vector 0 of the set is the seed.

The search does not try increments directly. It tries their odd modular inverses Y instead. For a candidate Y, the step count needed to reach vector i is (Y·(Vi − V0)) mod 2^NB, and the sequence length for that Y is the largest of these counts. A bound register is settled one bit at a time, starting from the top bit. For each bit, the block clears the bit on trial and scans the odd Y values, one per clock. The bit stays clear if some Y meets the trial bound. Once every bit is settled, the block inverts the winning Y bit-serially to give the increment, and then pulses done.

Vectors are written through an index/data/write-enable port while the block is idle. A one-cycle start pulse launches a search.

Top module: `incr_search`

## Requirements
- R1: After a synchronous reset, busy and done are 0, minLen is all ones (2^NB−1), and bestY and incr are both 1.
- R2: A write (wrEn high) stores wrData at index wrIdx only when the block is idle and wrIdx < NV. A write made while busy, or with wrIdx ≥ NV, has no effect on any later result.
- R3: At done, minLen equals the minimum, over all odd Y in 1..2^NB−1, of the maximum over i of (Y·((Vi − V0) mod 2^NB)) mod 2^NB. Vector index 0 is the seed.
- R4: At done, bestY is the smallest odd Y whose maximum equals minLen.
- R5: At done, incr is odd and (incr·bestY) mod 2^NB = 1.
- R6: done is high for exactly one cycle per search. busy is high from the cycle after start until done falls.
- R7: A start pulse while busy is ignored and does not change the running search's results.
- R8: With NB=6 and the vectors {0,59,60,61,62}, the result is minLen=5, bestY=63 and incr=63.
- R9: When every vector equals the seed, whatever the seed value, the result is minLen=0, bestY=1 and incr=1.
- R10: done rises no more than NB·2^(NB−1)+NB clock edges after the edge that samples start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Vector write enable |
| wrIdx | input | $clog2(NV) | Vector index to write |
| wrData | input | NB | Vector value |
| start | input | 1 | Start-search pulse |
| minLen | output | NB | Minimal sequence length |
| bestY | output | NB | Winning inverse increment |
| incr | output | NB | Increment, the inverse of bestY |
| done | output | 1 | One-cycle result-valid pulse |
| busy | output | 1 | Search or inversion in progress |

## Verification
Each fault has a visible result at the ports:
- A bound bit settled wrongly shows as a minLen that differs from the brute-force minimum. The result is off by at least the weight of that bit, and it appears at the very next done.
- A candidate scan that skips or repeats values gives a wrong or non-minimal bestY.
- A bit-serial inversion that misses a bit breaks the product check on incr in the done cycle.
- Control faults show as a missing or stretched done, or as a latency beyond the bound.

Random vector sets with nonzero seeds exercise the modular wrap of the differences.

// File: rtl/incsrch_pkg.sv
package incsrch_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_INV, ST_DONE} ctlState_t;

  typedef struct packed {
    logic init;
    logic tryNext;
    logic acceptBit;
    logic rejectBit;
    logic invInit;
    logic invStep;
  } dpStrobe_t;
endpackage

// File: rtl/incsrch_dp.sv
module incsrch_dp
  import incsrch_pkg::*;
#(
  parameter int NB = 6,
  parameter int NV = 5,
  parameter int IW = $clog2(NV),
  parameter int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vecWr,
  input  logic [IW-1:0] wrIdx,
  input  logic [NB-1:0] wrData,
  input  dpStrobe_t     strb,
  input  logic [BW-1:0] bitSel,
  input  logic [BW-1:0] invSel,
  output logic          feasible,
  output logic          yLast,
  output logic [NB-1:0] boundQ,
  output logic [NB-1:0] bestYQ,
  output logic [NB-1:0] invQ
);
  localparam logic [NB-1:0] ONE = NB'(1);
  localparam logic [NB-1:0] TWO = NB'(2);

  logic [NB-1:0] vecMem [NV];
  logic [NB-1:0] yReg;
  logic [NB-1:0] lens [NV];
  logic [NB-1:0] maxLen;
  logic [NB-1:0] trial;
  logic [2*NB-1:0] invFull;

  // Per-vector step count for the current candidate.
  for (genvar i = 0; i < NV; i++) begin : g_len
    logic [NB-1:0] diff;
    logic [2*NB-1:0] full;
    assign diff = vecMem[i] - vecMem[0];
    assign full = {{NB{1'b0}}, yReg} * {{NB{1'b0}}, diff};
    assign lens[i] = full[NB-1:0];
  end

  always_comb begin
    maxLen = '0;
    for (int i = 0; i < NV; i++)
      if (lens[i] > maxLen) maxLen = lens[i];
  end

  assign trial    = boundQ & ~(ONE << bitSel);
  assign feasible = (maxLen <= trial);
  assign yLast    = (yReg == {NB{1'b1}});
  assign invFull  = {{NB{1'b0}}, invQ} * {{NB{1'b0}}, bestYQ};

  always_ff @(posedge clk) begin
    if (rst) begin
      boundQ <= '1;
      yReg   <= ONE;
      bestYQ <= ONE;
      invQ   <= ONE;
      for (int i = 0; i < NV; i++) vecMem[i] <= '0;
    end else begin
      if (vecWr && (int'(wrIdx) < NV)) vecMem[wrIdx] <= wrData;
      if (strb.init) begin
        boundQ <= '1;
        yReg   <= ONE;
        bestYQ <= ONE;
      end
      if (strb.tryNext) yReg <= yReg + TWO;
      if (strb.acceptBit) begin
        boundQ[bitSel] <= 1'b0;
        bestYQ         <= yReg;
        yReg           <= ONE;
      end
      if (strb.rejectBit) yReg <= ONE;
      if (strb.invInit) invQ <= ONE;
      if (strb.invStep && invFull[invSel]) invQ[invSel] <= 1'b1;
    end
  end

  // R3
  bound_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.init |=> boundQ <= $past(boundQ));

  // R4
  accept_meets_bound_chk: assert property (@(posedge clk) disable iff (rst)
    strb.acceptBit |-> maxLen <= boundQ);
endmodule

// File: rtl/incsrch_ctl.sv
module incsrch_ctl
  import incsrch_pkg::*;
#(
  parameter int NB = 6,
  parameter int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          feasible,
  input  logic          yLast,
  output dpStrobe_t     strb,
  output logic [BW-1:0] bitSel,
  output logic [BW-1:0] invSel,
  output logic          busy,
  output logic          done
);
  localparam logic [BW-1:0] TOPBIT = BW'(NB-1);

  ctlState_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        strb.init = 1'b1;
        nextState = ST_SEARCH;
      end
      ST_SEARCH: begin
        if (feasible)   strb.acceptBit = 1'b1;
        else if (yLast) strb.rejectBit = 1'b1;
        else            strb.tryNext   = 1'b1;
        if ((feasible || yLast) && bitSel == '0) begin
          strb.invInit = 1'b1;
          nextState    = ST_INV;
        end
      end
      ST_INV: begin
        strb.invStep = 1'b1;
        if (invSel == TOPBIT) nextState = ST_DONE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitSel <= TOPBIT;
      invSel <= BW'(1);
    end else begin
      state <= nextState;
      if (strb.init) bitSel <= TOPBIT;
      else if ((strb.acceptBit || strb.rejectBit) && bitSel != '0) bitSel <= bitSel - BW'(1);
      if (strb.invInit) invSel <= BW'(1);
      else if (strb.invStep && invSel != TOPBIT) invSel <= invSel + BW'(1);
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
endmodule

// File: rtl/incr_search.sv
module incr_search
  import incsrch_pkg::*;
#(
  parameter int NB = 6,
  parameter int NV = 5,
  localparam int IW = $clog2(NV),
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic [NB-1:0] wrData,
  input  logic          start,
  output logic [NB-1:0] minLen,
  output logic [NB-1:0] bestY,
  output logic [NB-1:0] incr,
  output logic          done,
  output logic          busy
);
  dpStrobe_t     strb;
  logic [BW-1:0] bitSel, invSel;
  logic          feasible, yLast;
  logic [2*NB-1:0] prodChk;

  incsrch_ctl #(.NB(NB), .BW(BW)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .feasible(feasible), .yLast(yLast),
    .strb(strb), .bitSel(bitSel), .invSel(invSel), .busy(busy), .done(done)
  );

  incsrch_dp #(.NB(NB), .NV(NV), .IW(IW), .BW(BW)) u_dp (
    .clk(clk), .rst(rst), .vecWr(wrEn && !busy), .wrIdx(wrIdx), .wrData(wrData),
    .strb(strb), .bitSel(bitSel), .invSel(invSel), .feasible(feasible),
    .yLast(yLast), .boundQ(minLen), .bestYQ(bestY), .invQ(incr)
  );

  assign prodChk = {{NB{1'b0}}, incr} * {{NB{1'b0}}, bestY};

  // R5
  inverse_ok_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> prodChk[NB-1:0] == NB'(1));
endmodule

// File: tb/tb_incr_search.sv
module tb_incr_search;
  localparam int NB = 6;
  localparam int NV = 5;
  localparam int IW = $clog2(NV);
  localparam int MASK = (1 << NB) - 1;
  localparam int LAT = NB * (1 << (NB - 1)) + NB;

  logic clk = 0, rst = 1, wrEn = 0, start = 0;
  logic [IW-1:0] wrIdx = '0;
  logic [NB-1:0] wrData = '0;
  logic [NB-1:0] minLen, bestY, incr;
  logic done, busy;

  int nChecks = 0, nFails = 0, cyc = 0;
  int vset [NV];

  always #5 clk = ~clk;

  incr_search #(.NB(NB), .NV(NV)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .start(start), .minLen(minLen), .bestY(bestY), .incr(incr),
    .done(done), .busy(busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void refSolve(output int mn, output int by, output int inv);
    mn = MASK + 1; by = 1; inv = 1;
    for (int y = 1; y <= MASK; y += 2) begin
      int mx = 0;
      for (int i = 0; i < NV; i++) begin
        int l = (y * ((vset[i] - vset[0]) & MASK)) & MASK;
        if (l > mx) mx = l;
      end
      if (mx < mn) begin mn = mx; by = y; end
    end
    for (int x = 1; x <= MASK; x += 2)
      if (((x * by) & MASK) == 1) inv = x;
  endfunction

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    wrEn = 1; wrIdx = IW'(idx); wrData = NB'(val);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic loadSet();
    for (int i = 0; i < NV; i++) wr(i, vset[i]);
  endtask

  // Launch a search, optionally disturbing it while busy, then check.
  task automatic runCheck(input string tag, input bit disturb);
    int cnt = 0, mn, by, inv;
    refSolve(mn, by, inv);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; cnt = 1;
    if (disturb) begin
      // R2: write while busy must be dropped; R7: start while busy ignored
      wrEn = 1; wrIdx = IW'(1); wrData = NB'(vset[1] ^ 5);
      start = 1;
      @(negedge clk); cnt++;
      wrEn = 0; start = 0;
    end
    while (!done && cnt < 4 * LAT) begin @(negedge clk); cnt++; end
    chk({tag, " R10 latency within bound"}, (cnt <= LAT) ? 1 : 0, 1);
    chk({tag, " R3 minLen"}, int'(minLen), mn);
    chk({tag, " R4 bestY"}, int'(bestY), by);
    chk({tag, " R5 incr"}, int'(incr), inv);
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, int'(done), 0);
    chk({tag, " R6 busy drops"}, int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 minLen", int'(minLen), MASK);
    chk("R1 bestY", int'(bestY), 1);
    chk("R1 incr", int'(incr), 1);

    // R8 directed example
    vset = '{0, 59, 60, 61, 62};
    loadSet();
    runCheck("R8", 0);
    chk("R8 minLen literal", int'(minLen), 5);
    chk("R8 bestY literal", int'(bestY), 63);
    chk("R8 incr literal", int'(incr), 63);

    // R9 all vectors equal a nonzero seed
    vset = '{37, 37, 37, 37, 37};
    loadSet();
    runCheck("R9", 0);
    chk("R9 minLen zero", int'(minLen), 0);
    chk("R9 bestY one", int'(bestY), 1);

    // R2 and R7: disturbance while busy has no effect
    vset = '{60, 3, 17, 44, 9};
    loadSet();
    runCheck("R2R7 busy", 1);
    runCheck("R2 rerun", 0);
    wr(6, 11);
    runCheck("R2 bad index", 0);

    // R3/R4/R5 random sets, including wrapping differences
    for (int t = 0; t < 25; t++) begin
      for (int i = 0; i < NV; i++) vset[i] = int'($urandom_range(MASK, 0));
      loadSet();
      runCheck("rand", 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule